// File: doc/BRIEF.md
# Board Control Register Block

This block is the control-register window of a development board's system logic. A host reaches it over a simple 32-bit read/write bus. Only the low 20 bits of the bus address select a register. The block drives an 8-LED bar and an 8-character ASCII display. It can issue a one-cycle system reset request and reports the board switches. It also gives software a bit-banged I2C port: an output-enable register, an output register that drives the clock and data lines toward an attached EEPROM, a select bit, and an input register. The input register reflects the EEPROM's data line.

The display can be loaded two ways. A write to the word register shows the written 32-bit value as eight uppercase hex digits. A write to one of eight per-position byte registers replaces a single character. Reads return data one cycle after the request. A read of an offset that maps to nothing returns zero and raises a one-cycle bad-access flag beside the data.

Top module: `brdctl_regs`

Register offsets (low 20 bits): switch 0x00200, LED bar 0x00408, display word 0x00410, character k at 0x00418 + 8·k (k = 0..7), soft reset 0x00500, general-purpose output 0x00A00, I2C input 0x00B00, I2C output enable 0x00B08, I2C output 0x00B10, I2C select 0x00B18.

## Requirements
- R1: Address bits above bit 19 are ignored. Any address whose low 20 bits equal a register offset reaches that register.
- R2: The LED bar register keeps bits 7:0 of the written data, and `led[7]` is the leftmost LED. The register reads back zero-extended and changes only on a write to its offset.
- R3: A write to the display word register shows the data as eight uppercase hex ASCII digits. The most significant nibble goes to character 0 (the leftmost, `disp_text[7:0]`), and leading zeros are kept.
- R4: A write to offset 0x00418 + 8·k stores data bits 7:0 as character k (`disp_text[8k+7:8k]`) and leaves the other characters unchanged. A read at that offset returns the character zero-extended.
- R5: Any write to the soft reset offset raises `rst_req` for exactly one cycle, in the cycle after the write. No register of the block changes as a result.
- R6: A read of the switch register returns 0x00000000 (all switches closed).
- R7: The I2C output-enable register keeps data bits 1:0. The I2C select register keeps bit 0. The general-purpose output register keeps bits 7:0. Each reads back masked to its width.
- R8: On a write to the I2C output register, data bit 1 drives `i2c_scl` and data bit 0 drives `i2c_sda`. A read returns {scl, sda} in bits 1:0.
- R9: A read of the I2C input register returns bits 7:1 of the sampled `i2c_in` pins. Bit 0 is replaced by the level of `eep_sda` in the read cycle.
- R10: After reset the display holds eight spaces (0x20), `i2c_scl` and `i2c_sda` are 1, and the LED, general-purpose output, output enable, select and `rst_req` are 0.
- R11: A read of an unmapped offset (including a character offset not on an 8-byte step) returns zero with `rd_bad` high for that one cycle. A write to an unmapped offset changes no output.
- R12: Read data and `rd_valid` appear in the cycle after `bus_rd` is sampled. The display word and soft reset registers read as zero without `rd_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address, low 20 bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| rd_bad | output | 1 | Read hit an unmapped offset |
| led | output | 8 | LED bar, bit 7 leftmost |
| disp_text | output | 64 | Eight ASCII characters, character 0 in bits 7:0 |
| rst_req | output | 1 | One-cycle system reset request |
| gpo | output | 8 | General-purpose output |
| i2c_oe | output | 2 | I2C output enables |
| i2c_sel | output | 1 | I2C select |
| i2c_scl | output | 1 | I2C clock toward EEPROM |
| i2c_sda | output | 1 | I2C data toward EEPROM |
| i2c_in | input | 8 | I2C input pins |
| eep_sda | input | 1 | Data line driven by the EEPROM |

## Verification
Each register drives an output directly. A wrong stored value therefore shows on its pin at the first sample after the write that set it. A write that lands on the wrong register shows on another output in that same cycle. A decode error instead shows on the read path one cycle after the read, either as wrong data or as a spurious or missing `rd_bad`. A fault in the display's digit conversion or character indexing shows as one wrong byte in `disp_text`. A reset pulse that is too long, missing, or that also clears state shows on `rst_req` or on the LED bar within two cycles.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;
  localparam int OFFW = 20;

  localparam logic [OFFW-1:0] OFF_SWITCH  = 20'h00200;
  localparam logic [OFFW-1:0] OFF_LED     = 20'h00408;
  localparam logic [OFFW-1:0] OFF_WORD    = 20'h00410;
  localparam logic [OFFW-1:0] OFF_CHAR0   = 20'h00418;
  localparam int              CHAR_STEP   = 8;
  localparam logic [OFFW-1:0] OFF_SOFTRES = 20'h00500;
  localparam logic [OFFW-1:0] OFF_GPO     = 20'h00A00;
  localparam logic [OFFW-1:0] OFF_I2CIN   = 20'h00B00;
  localparam logic [OFFW-1:0] OFF_I2COE   = 20'h00B08;
  localparam logic [OFFW-1:0] OFF_I2COUT  = 20'h00B10;
  localparam logic [OFFW-1:0] OFF_I2CSEL  = 20'h00B18;

  localparam logic [7:0] ASCII_SPACE = 8'h20;

  typedef enum logic [3:0] {
    RID_NONE, RID_SWITCH, RID_LED, RID_WORD, RID_CHAR, RID_SOFTRES,
    RID_GPO, RID_I2CIN, RID_I2COE, RID_I2COUT, RID_I2CSEL
  } reg_id_e;

  function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
    return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
  endfunction
endpackage

// File: rtl/brdctl_decode.sv
module brdctl_decode
  import brdctl_pkg::*;
#(
  parameter int NCHAR = 8,
  localparam int IW = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic [OFFW-1:0] offset,
  output reg_id_e         reg_id,
  output logic [IW-1:0]   char_idx
);
  localparam logic [OFFW-1:0] CHAR_LAST = OFF_CHAR0 + OFFW'(CHAR_STEP * (NCHAR - 1));

  logic [OFFW-1:0] rel;
  logic            in_char;

  assign rel      = offset - OFF_CHAR0;
  assign in_char  = (offset >= OFF_CHAR0) && (offset <= CHAR_LAST) && (rel[2:0] == 3'b000);
  assign char_idx = rel[3 +: IW];

  always_comb begin
    reg_id = RID_NONE;
    unique case (offset)
      OFF_SWITCH:  reg_id = RID_SWITCH;
      OFF_LED:     reg_id = RID_LED;
      OFF_WORD:    reg_id = RID_WORD;
      OFF_SOFTRES: reg_id = RID_SOFTRES;
      OFF_GPO:     reg_id = RID_GPO;
      OFF_I2CIN:   reg_id = RID_I2CIN;
      OFF_I2COE:   reg_id = RID_I2COE;
      OFF_I2COUT:  reg_id = RID_I2COUT;
      OFF_I2CSEL:  reg_id = RID_I2CSEL;
      default:     reg_id = in_char ? RID_CHAR : RID_NONE;
    endcase
  end
endmodule

// File: rtl/brdctl_display.sv
module brdctl_display
  import brdctl_pkg::*;
#(
  parameter int DW = 32,
  localparam int NCHAR = DW / 4,
  localparam int IW = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_we,
  input  logic               pos_we,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wdata,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_char,
  output logic [8*NCHAR-1:0] text
);
  logic [7:0] chr_q [NCHAR];
  logic [7:0] chr_d [NCHAR];
  logic       chr_ce;

  assign chr_ce = word_we | pos_we;

  always_comb begin
    for (int k = 0; k < NCHAR; k++) chr_d[k] = chr_q[k];
    if (word_we) begin
      for (int k = 0; k < NCHAR; k++) chr_d[k] = hex_ascii(wdata[DW-1-4*k -: 4]);
    end
    if (pos_we) chr_d[wr_idx] = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCHAR; k++) chr_q[k] <= ASCII_SPACE;
    end else if (chr_ce) begin
      for (int k = 0; k < NCHAR; k++) chr_q[k] <= chr_d[k];
    end
  end

  for (genvar g = 0; g < NCHAR; g++) begin : g_flat
    assign text[8*g +: 8] = chr_q[g];
  end

  assign rd_char = chr_q[rd_idx];
endmodule

// File: rtl/brdctl_i2c.sv
module brdctl_i2c (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_we,
  input  logic       out_we,
  input  logic       sel_we,
  input  logic [7:0] wbyte,
  input  logic [7:0] pins_in,
  input  logic       eep_sda,
  output logic [1:0] oe,
  output logic       sel,
  output logic       scl,
  output logic       sda,
  output logic [7:0] in_view
);
  logic [1:0] oe_d, out_d, out_q;
  logic       sel_d;
  logic [7:0] in_q;

  always_comb begin
    oe_d  = wbyte[1:0];
    out_d = wbyte[1:0];
    sel_d = wbyte[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe    <= 2'b00;
      out_q <= 2'b11;
      sel   <= 1'b0;
      in_q  <= 8'h00;
    end else begin
      if (oe_we)  oe    <= oe_d;
      if (out_we) out_q <= out_d;
      if (sel_we) sel   <= sel_d;
      in_q <= pins_in;
    end
  end

  assign scl     = out_q[1];
  assign sda     = out_q[0];
  assign in_view = {in_q[7:1], eep_sda};
endmodule

// File: rtl/brdctl_regs.sv
module brdctl_regs
  import brdctl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NCHAR = DW / 4,
  localparam int IW = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               rd_valid,
  output logic               rd_bad,
  output logic [7:0]         led,
  output logic [8*NCHAR-1:0] disp_text,
  output logic               rst_req,
  output logic [7:0]         gpo,
  output logic [1:0]         i2c_oe,
  output logic               i2c_sel,
  output logic               i2c_scl,
  output logic               i2c_sda,
  input  logic [7:0]         i2c_in,
  input  logic               eep_sda
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[AW-1:OFFW];

  reg_id_e       rid;
  logic [IW-1:0] cidx;

  brdctl_decode #(.NCHAR(NCHAR)) u_dec (
    .offset  (bus_addr[OFFW-1:0]),
    .reg_id  (rid),
    .char_idx(cidx)
  );

  logic [7:0] rd_char;
  brdctl_display #(.DW(DW)) u_disp (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .word_we(bus_wr && rid == RID_WORD),
    .pos_we (bus_wr && rid == RID_CHAR),
    .wr_idx (cidx),
    .wdata  (bus_wdata),
    .rd_idx (cidx),
    .rd_char(rd_char),
    .text   (disp_text)
  );

  logic [7:0] i2c_view;
  brdctl_i2c u_i2c (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .oe_we  (bus_wr && rid == RID_I2COE),
    .out_we (bus_wr && rid == RID_I2COUT),
    .sel_we (bus_wr && rid == RID_I2CSEL),
    .wbyte  (bus_wdata[7:0]),
    .pins_in(i2c_in),
    .eep_sda(eep_sda),
    .oe     (i2c_oe),
    .sel    (i2c_sel),
    .scl    (i2c_scl),
    .sda    (i2c_sda),
    .in_view(i2c_view)
  );

  // LED bar, general-purpose output, reset request
  logic led_ce, gpo_ce, rst_req_d;
  logic [7:0] led_d, gpo_d;

  always_comb begin
    led_ce    = bus_wr && rid == RID_LED;
    gpo_ce    = bus_wr && rid == RID_GPO;
    led_d     = bus_wdata[7:0];
    gpo_d     = bus_wdata[7:0];
    rst_req_d = bus_wr && rid == RID_SOFTRES;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      led     <= 8'h00;
      gpo     <= 8'h00;
      rst_req <= 1'b0;
    end else begin
      if (led_ce) led <= led_d;
      if (gpo_ce) gpo <= gpo_d;
      rst_req <= rst_req_d;
    end
  end

  // Read path
  logic [DW-1:0] rdata_d;
  logic          bad_d;

  always_comb begin
    rdata_d = '0;
    bad_d   = 1'b0;
    unique case (rid)
      RID_LED:    rdata_d[7:0] = led;
      RID_CHAR:   rdata_d[7:0] = rd_char;
      RID_GPO:    rdata_d[7:0] = gpo;
      RID_I2CIN:  rdata_d[7:0] = i2c_view;
      RID_I2COE:  rdata_d[1:0] = i2c_oe;
      RID_I2COUT: rdata_d[1:0] = {i2c_scl, i2c_sda};
      RID_I2CSEL: rdata_d[0]   = i2c_sel;
      RID_NONE:   bad_d        = 1'b1;
      default:    rdata_d      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
      rd_bad    <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      rd_bad   <= bus_rd && bad_d;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/brdctl_regs_chk.sv
module brdctl_regs_chk
  import brdctl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NCHAR = DW / 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic               rd_valid,
  input logic               rd_bad,
  input logic [7:0]         led,
  input logic [8*NCHAR-1:0] disp_text,
  input logic               rst_req,
  input logic [7:0]         gpo,
  input logic [1:0]         i2c_oe,
  input logic               i2c_sel,
  input logic               i2c_scl,
  input logic               i2c_sda,
  input logic [7:0]         i2c_in,
  input logic               eep_sda
);
  p_rst_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_rst_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(bus_wr && bus_addr[OFFW-1:0] == OFF_SOFTRES));

  p_bad_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (rd_valid && bus_rdata == '0));

  p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd) |-> rd_valid);

  p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(led));

  p_i2c_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr[OFFW-1:0] == OFF_I2COUT) |->
      (i2c_scl == $past(bus_wdata[1]) && i2c_sda == $past(bus_wdata[0])));

  p_i2c_in_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr[OFFW-1:0] == OFF_I2CIN) |-> bus_rdata[0] == $past(eep_sda));

  p_oe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr[OFFW-1:0] == OFF_I2COE) |-> bus_rdata[DW-1:2] == '0);

  p_disp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> $stable(disp_text));
endmodule

bind brdctl_regs brdctl_regs_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/brdctl_regs_bench.sv
module brdctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rd_valid, rd_bad;
  logic [7:0]  led, gpo, i2c_in;
  logic [63:0] disp_text;
  logic        rst_req, i2c_sel, i2c_scl, i2c_sda, eep_sda;
  logic [1:0]  i2c_oe;

  always #2 clk = ~clk; // 250 MHz

  brdctl_regs u_brdctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_bad(rd_bad),
    .led(led), .disp_text(disp_text), .rst_req(rst_req), .gpo(gpo), .i2c_oe(i2c_oe),
    .i2c_sel(i2c_sel), .i2c_scl(i2c_scl), .i2c_sda(i2c_sda), .i2c_in(i2c_in),
    .eep_sda(eep_sda)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        bad;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q [$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned read against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected read data", 64'(rd_valid), 64'd0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check({it.tag, " rdata"}, 64'(bus_rdata), 64'(it.data));
        check({it.tag, " rd_bad"}, 64'(rd_bad), 64'(it.bad));
      end
    end
  end

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [31:0] d, input logic bad,
                          input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.data = d; it.bad = bad; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " R12 rd_valid one cycle later"}, 64'(rd_valid), 64'd1);
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] v);
    logic [63:0] t;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] n;
      n = v[31-4*k -: 4];
      t[8*k +: 8] = (n < 10) ? (8'd48 + 8'(n)) : (8'd55 + 8'(n));
    end
    return t;
  endfunction

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    i2c_in = 8'h00; eep_sda = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 display spaces", disp_text, {8{8'h20}});
    check("R10 led", 64'(led), 64'd0);
    check("R10 gpo", 64'(gpo), 64'd0);
    check("R10 scl/sda idle high", 64'({i2c_scl, i2c_sda}), 64'd3);
    check("R10 oe/sel", 64'({i2c_oe, i2c_sel}), 64'd0);
    check("R10 rst_req", 64'(rst_req), 64'd0);

    // R6 switches
    bus_read(32'h0000_0200, 32'h0, 1'b0, "R6 switch");

    // R2 LED bar
    bus_write(32'h0000_0408, 32'hABCD_12F5);
    check("R2 led low byte", 64'(led), 64'hF5);
    check("R2 led bit7 leftmost", 64'(led[7]), 64'd1);
    bus_read(32'h0000_0408, 32'h0000_00F5, 1'b0, "R2 led readback");

    // R1 upper address bits ignored
    bus_write(32'hFFF0_0408, 32'h0000_003C);
    check("R1 aliased write", 64'(led), 64'h3C);
    bus_read(32'h1230_0408, 32'h0000_003C, 1'b0, "R1 aliased read");

    // R3 word display
    bus_write(32'h0000_0410, 32'h0123_ABEF);
    check("R3 hex word", disp_text, hex_text(32'h0123_ABEF));
    bus_write(32'h0000_0410, 32'hFEDC_0009);
    check("R3 hex word zero padded", disp_text, hex_text(32'hFEDC_0009));
    bus_read(32'h0000_0410, 32'h0, 1'b0, "R12 word reads zero");

    // R4 per-position characters
    begin
      logic [63:0] e;
      e = hex_text(32'hFEDC_0009);
      bus_write(32'h0000_0440, 32'h1234_5641); // char 5
      e[8*5 +: 8] = 8'h41;
      check("R4 char5", disp_text, e);
      bus_write(32'h0000_0418, 32'h0000_007A); // char 0
      e[7:0] = 8'h7A;
      check("R4 char0", disp_text, e);
      bus_write(32'h0000_0450, 32'h0000_0021); // char 7
      e[63:56] = 8'h21;
      check("R4 char7", disp_text, e);
      bus_read(32'h0000_0440, 32'h0000_0041, 1'b0, "R4 char5 readback");

      // R5 soft reset pulse, no clearing
      @(negedge clk);
      bus_addr = 32'h0000_0500; bus_wdata = 32'h1; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R5 rst_req high", 64'(rst_req), 64'd1);
      @(negedge clk);
      check("R5 rst_req single cycle", 64'(rst_req), 64'd0);
      check("R5 led kept", 64'(led), 64'h3C);
      check("R5 display kept", disp_text, e);
      bus_read(32'h0000_0500, 32'h0, 1'b0, "R12 softres reads zero");

      // R7 widths
      bus_write(32'h0000_0B08, 32'hFFFF_FFFF);
      check("R7 oe two bits", 64'(i2c_oe), 64'd3);
      bus_write(32'h0000_0B18, 32'hFFFF_FFFE);
      check("R7 sel bit0", 64'(i2c_sel), 64'd0);
      bus_write(32'h0000_0B18, 32'h0000_0003);
      check("R7 sel set", 64'(i2c_sel), 64'd1);
      bus_write(32'h0000_0A00, 32'h0000_01A5);
      check("R7 gpo", 64'(gpo), 64'hA5);
      bus_read(32'h0000_0B08, 32'h3, 1'b0, "R7 oe readback");
      bus_read(32'h0000_0B18, 32'h1, 1'b0, "R7 sel readback");
      bus_read(32'h0000_0A00, 32'hA5, 1'b0, "R7 gpo readback");

      // R8 I2C lines
      bus_write(32'h0000_0B10, 32'hFFFF_FFF2);
      check("R8 scl=1 sda=0", 64'({i2c_scl, i2c_sda}), 64'b10);
      bus_write(32'h0000_0B10, 32'h0000_0001);
      check("R8 scl=0 sda=1", 64'({i2c_scl, i2c_sda}), 64'b01);
      bus_read(32'h0000_0B10, 32'h1, 1'b0, "R8 out readback");

      // R9 I2C input
      i2c_in = 8'hA4; eep_sda = 1'b1;
      repeat (2) @(negedge clk);
      bus_read(32'h0000_0B00, 32'hA5, 1'b0, "R9 input sda=1");
      i2c_in = 8'h5B; eep_sda = 1'b0;
      repeat (2) @(negedge clk);
      bus_read(32'h0000_0B00, 32'h5A, 1'b0, "R9 input sda=0");

      // R11 unmapped
      bus_read(32'h0000_0300, 32'h0, 1'b1, "R11 unmapped read");
      bus_read(32'h0000_041C, 32'h0, 1'b1, "R11 misaligned char read");
      bus_read(32'h0000_0458, 32'h0, 1'b1, "R11 past last char read");
      bus_write(32'h0000_0300, 32'hFFFF_FFFF);
      bus_write(32'h0000_041C, 32'hFFFF_FFFF);
      check("R11 led untouched", 64'(led), 64'h3C);
      check("R11 gpo untouched", 64'(gpo), 64'hA5);
      check("R11 display untouched", disp_text, e);
      check("R11 i2c untouched", 64'({i2c_oe, i2c_sel, i2c_scl, i2c_sda}), 64'b11101);
      check("R11 no reset request", 64'(rst_req), 64'd0);
    end

    repeat (3) @(negedge clk);
    check("R12 all reads returned", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule